// File: doc/BRIEF.md
# Byte-Wide Binary Function Unit

This block is a purely combinational two-operand function unit. It takes two full-width operand bytes and a three-bit function code, and returns one result byte. The function code selects binary add or subtract, packed decimal add or subtract, a bitwise AND, OR or XOR, or an equality test that returns a mask byte. A core places it on the datapath where a result byte is needed from two source bytes. It feeds the low three bits of an instruction opcode straight into the function code.

There are no carry, borrow or flag pins. Each function maps the pair of bytes to a single result byte, the way one entry of a precomputed lookup would. Carries that leave the top of the byte are discarded. The decimal functions work digit by digit on four-bit nibbles. Each nibble is corrected by six when it leaves the decimal range. The same rule is applied to nibbles that are not decimal digits, so every input pair has a defined result.

Top module: `byte_fn_unit`

## Requirements
- R1: With fn_sel = 0, result equals (op_a + op_b) modulo 256, and the carry out is dropped.
- R2: With fn_sel = 1 and both operands valid packed decimal (each nibble 0 to 9, value 00 to 99), result is the packed decimal form of (op_a + op_b) modulo 100.
- R3: With fn_sel = 2, result equals (op_a − op_b) modulo 256, and the borrow out is dropped.
- R4: With fn_sel = 3 and both operands valid packed decimal, result is the packed decimal form of (op_a − op_b) modulo 100, so a negative difference wraps (00 − 01 gives 0x99).
- R5: With fn_sel = 4, result is the bitwise AND of the operands.
- R6: With fn_sel = 5, result is the bitwise OR of the operands.
- R7: With fn_sel = 6, result is the bitwise XOR of the operands.
- R8: With fn_sel = 7, result is 0x00 when op_a equals op_b and 0xFF otherwise.
- R9: For any nibbles, the decimal functions work from the low digit to the high digit, and the carry or borrow into the lowest digit is 0. For add, s = a + b + carry; if s > 9 the digit is (s + 6) mod 16 with carry 1, otherwise it is s with carry 0. For subtract, d = a − b − borrow; if d < 0 the digit is (d + 10) mod 16 with borrow 1, otherwise it is d with borrow 0. Two examples: 0x0F decimal-plus 0x00 gives 0x15, and 0x00 decimal-minus 0x0F gives 0x9B.
- R10: The result depends only on the present inputs and holds no state. A change of input shows at result in the same time step, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 (WIDTH) | First operand byte (minuend for subtraction) |
| op_b | input | 8 (WIDTH) | Second operand byte (subtrahend for subtraction) |
| fn_sel | input | 3 | Function code: 0 add, 1 decimal add, 2 subtract, 3 decimal subtract, 4 AND, 5 OR, 6 XOR, 7 equality mask |
| result | output | 8 (WIDTH) | Result byte of the selected function |

## Verification
Each time the inputs change, the assertions check algebraic relations at the ports. For add and subtract, undoing the operation gives back op_a. XOR with op_b gives back op_a. The AND result lies within each operand and the OR result covers both. The equality mask is all-zeros exactly when the operands match, and all-ones otherwise. When both inputs are valid packed decimal, the decimal results must also be valid packed decimal. Only the bench's scenarios can show the exact decimal sums and differences, including the wrap past 99 and below 00. The same holds for the nibble-correction values on non-decimal inputs and for the fact that the result follows its inputs without any clock. The bench covers these with a full sweep of all decimal operand pairs, corner and random operands for every code, and named non-decimal examples.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   localparam int FN_BITS = 3;

   typedef enum logic [FN_BITS-1:0] {
      FN_ADD  = 3'd0,
      FN_DADD = 3'd1,
      FN_SUB  = 3'd2,
      FN_DSUB = 3'd3,
      FN_AND  = 3'd4,
      FN_OR   = 3'd5,
      FN_XOR  = 3'd6,
      FN_EQM  = 3'd7
   } fn_code_e;

   localparam int DIGIT_BITS = 4;
endpackage

// File: rtl/bfu_bin_arith.sv
module bfu_bin_arith #(
   parameter int WIDTH        = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             is_sub_i,
   output logic [WIDTH-1:0] y_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("bfu_bin_arith: WIDTH must be at least 1");
   end

   if (SHARED_ADDER) begin : g_shared
      // One carry chain: subtraction adds the inverted operand plus one.
      logic [WIDTH-1:0] b_mod;
      logic [WIDTH-1:0] cin_ext;
      assign b_mod   = b_i ^ {WIDTH{is_sub_i}};
      assign cin_ext = {{(WIDTH-1){1'b0}}, is_sub_i};
      assign y_o     = a_i + b_mod + cin_ext;
   end else begin : g_split
      // Two chains in parallel, chosen after the fact.
      logic [WIDTH-1:0] sum_w;
      logic [WIDTH-1:0] dif_w;
      assign sum_w = a_i + b_i;
      assign dif_w = a_i - b_i;
      assign y_o   = is_sub_i ? dif_w : sum_w;
   end
endmodule

// File: rtl/bfu_dec_arith.sv
module bfu_dec_arith
   import bfu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             is_sub_i,
   output logic [WIDTH-1:0] y_o
);
   localparam int DIGITS = WIDTH / DIGIT_BITS;

   if ((WIDTH % DIGIT_BITS) != 0 || DIGITS < 1) begin : g_bad_width
      $error("bfu_dec_arith: WIDTH must be a non-zero multiple of 4");
   end

   // Carry (add) or borrow (sub) into each digit; the lowest digit takes none.
   logic [DIGITS-1:0] cy;
   assign cy[0] = 1'b0;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      logic [3:0] an;
      logic [3:0] bn;
      logic [4:0] raw_add;
      logic [4:0] raw_sub;
      logic       add_fix;
      logic       sub_fix;
      logic [3:0] sum_n;
      logic [3:0] dif_n;

      assign an      = a_i[g*DIGIT_BITS +: DIGIT_BITS];
      assign bn      = b_i[g*DIGIT_BITS +: DIGIT_BITS];
      assign raw_add = {1'b0, an} + {1'b0, bn} + {4'b0000, cy[g]};
      assign raw_sub = {1'b0, an} - {1'b0, bn} - {4'b0000, cy[g]};
      assign add_fix = raw_add > 5'd9;
      assign sub_fix = raw_sub[4];
      assign sum_n   = raw_add[3:0] + (add_fix ? 4'd6 : 4'd0);
      assign dif_n   = raw_sub[3:0] - (sub_fix ? 4'd6 : 4'd0);

      assign y_o[g*DIGIT_BITS +: DIGIT_BITS] = is_sub_i ? dif_n : sum_n;

      if (g < DIGITS - 1) begin : g_chain
         assign cy[g+1] = is_sub_i ? sub_fix : add_fix;
      end
   end
endmodule

// File: rtl/bfu_logic.sv
module bfu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] xor_o,
   output logic [WIDTH-1:0] eqm_o
);
   logic differ;

   assign and_o  = a_i & b_i;
   assign or_o   = a_i | b_i;
   assign xor_o  = a_i ^ b_i;
   assign differ = |xor_o;
   assign eqm_o  = {WIDTH{differ}};
endmodule

// File: rtl/byte_fn_unit.sv
module byte_fn_unit
   import bfu_pkg::*;
#(
   parameter int WIDTH        = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0]   op_a,
   input  logic [WIDTH-1:0]   op_b,
   input  logic [FN_BITS-1:0] fn_sel,
   output logic [WIDTH-1:0]   result
);
   if ((WIDTH % DIGIT_BITS) != 0 || WIDTH < DIGIT_BITS) begin : g_bad_width
      $error("byte_fn_unit: WIDTH must be a non-zero multiple of 4");
   end

   fn_code_e         code;
   logic             sub_mode;
   logic [WIDTH-1:0] bin_y;
   logic [WIDTH-1:0] dec_y;
   logic [WIDTH-1:0] and_y;
   logic [WIDTH-1:0] or_y;
   logic [WIDTH-1:0] xor_y;
   logic [WIDTH-1:0] eqm_y;

   assign code     = fn_code_e'(fn_sel);
   // Codes 2 and 3 subtract, codes 0 and 1 add.
   assign sub_mode = fn_sel[1];

   bfu_bin_arith #(
      .WIDTH        (WIDTH),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_bin (
      .a_i      (op_a),
      .b_i      (op_b),
      .is_sub_i (sub_mode),
      .y_o      (bin_y)
   );

   bfu_dec_arith #(
      .WIDTH (WIDTH)
   ) u_dec (
      .a_i      (op_a),
      .b_i      (op_b),
      .is_sub_i (sub_mode),
      .y_o      (dec_y)
   );

   bfu_logic #(
      .WIDTH (WIDTH)
   ) u_logic (
      .a_i   (op_a),
      .b_i   (op_b),
      .and_o (and_y),
      .or_o  (or_y),
      .xor_o (xor_y),
      .eqm_o (eqm_y)
   );

   always_comb begin
      unique case (code)
         FN_ADD, FN_SUB:   result = bin_y;
         FN_DADD, FN_DSUB: result = dec_y;
         FN_AND:           result = and_y;
         FN_OR:            result = or_y;
         FN_XOR:           result = xor_y;
         FN_EQM:           result = eqm_y;
         default:          result = '0;
      endcase
   end
endmodule

// File: rtl/byte_fn_unit_chk.sv
module byte_fn_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [2:0]       fn_sel,
   input logic [WIDTH-1:0] result
);
   localparam int NDIG = WIDTH / 4;

   function automatic bit is_dec(input logic [WIDTH-1:0] v);
      bit ok = 1'b1;
      for (int i = 0; i < NDIG; i++) begin
         if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
      end
      return ok;
   endfunction

   always_comb begin
      if (fn_sel == 3'd0) begin
         p_add_undo_r1: assert (result - op_b == op_a)
            else $error("add result does not undo to op_a");
      end
      if (fn_sel == 3'd2) begin
         p_sub_undo_r3: assert (result + op_b == op_a)
            else $error("sub result does not undo to op_a");
      end
      if (fn_sel == 3'd1 && is_dec(op_a) && is_dec(op_b)) begin
         p_dadd_digits_r2: assert (is_dec(result))
            else $error("decimal add produced a non-decimal digit");
      end
      if (fn_sel == 3'd3 && is_dec(op_a) && is_dec(op_b)) begin
         p_dsub_digits_r4: assert (is_dec(result))
            else $error("decimal sub produced a non-decimal digit");
      end
      if (fn_sel == 3'd4) begin
         p_and_within_r5: assert (((result & ~op_a) == '0) && ((result & ~op_b) == '0))
            else $error("AND result sets a bit absent from an operand");
      end
      if (fn_sel == 3'd5) begin
         p_or_covers_r6: assert (((op_a & ~result) == '0) && ((op_b & ~result) == '0))
            else $error("OR result misses an operand bit");
      end
      if (fn_sel == 3'd6) begin
         p_xor_undo_r7: assert ((result ^ op_b) == op_a)
            else $error("XOR result does not undo to op_a");
      end
      if (fn_sel == 3'd7) begin
         p_eqm_mask_r8: assert ((op_a == op_b) ? (result == '0) : (result == '1))
            else $error("equality mask wrong");
      end
   end
endmodule

bind byte_fn_unit byte_fn_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a   (op_a),
   .op_b   (op_b),
   .fn_sel (fn_sel),
   .result (result)
);

// File: tb/tb_byte_fn_unit.sv
`timescale 1ns/1ps
module tb_byte_fn_unit;
   logic       clk = 1'b0;
   logic [7:0] op_a = 8'h00;
   logic [7:0] op_b = 8'h00;
   logic [2:0] fn_sel = 3'd0;
   logic [7:0] result;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   byte_fn_unit #(.WIDTH(8)) dut (
      .op_a   (op_a),
      .op_b   (op_b),
      .fn_sel (fn_sel),
      .result (result)
   );

   // Nibble-correction rule of R9, written with integers.
   function automatic int nib_add(int a, int b);
      int c = 0, r = 0;
      for (int i = 0; i < 2; i++) begin
         int s = ((a >> (4*i)) & 15) + ((b >> (4*i)) & 15) + c;
         if (s > 9) begin s = s + 6; c = 1; end else c = 0;
         r = r | ((s % 16) << (4*i));
      end
      return r;
   endfunction

   function automatic int nib_sub(int a, int b);
      int c = 0, r = 0;
      for (int i = 0; i < 2; i++) begin
         int d = ((a >> (4*i)) & 15) - ((b >> (4*i)) & 15) - c;
         if (d < 0) begin d = d + 10; c = 1; end else c = 0;
         r = r | ((((d % 16) + 16) % 16) << (4*i));
      end
      return r;
   endfunction

   function automatic int model(int sel, int a, int b);
      case (sel)
         0: return (a + b) % 256;
         1: return nib_add(a, b);
         2: return (a - b + 256) % 256;
         3: return nib_sub(a, b);
         4: return a & b;
         5: return a | b;
         6: return a ^ b;
         default: return (a == b) ? 0 : 255;
      endcase
   endfunction

   function automatic bit dec_ok(int v);
      return ((v & 15) <= 9) && (((v >> 4) & 15) <= 9);
   endfunction

   function automatic string tag(int sel, int a, int b);
      string t[8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};
      if ((sel == 1 || sel == 3) && !(dec_ok(a) && dec_ok(b))) return "R9";
      return t[sel];
   endfunction

   task automatic check(string req, int exp);
      n_cmp++;
      if (int'(result) != exp) begin
         n_bad++;
         $display("FAIL %s sel=%0d a=%h b=%h actual=%h expected=%h",
                  req, fn_sel, op_a, op_b, result, exp[7:0]);
      end
   endtask

   // Drive on the rising edge, compare on the falling edge.
   task automatic apply(int sel, int a, int b, int exp, string req);
      @(posedge clk);
      fn_sel = sel[2:0]; op_a = a[7:0]; op_b = b[7:0];
      @(negedge clk);
      check(req, exp);
   endtask

   int corner[12] = '{8'h00, 8'h01, 8'h09, 8'h0F, 8'h10, 8'h7F,
                      8'h80, 8'h90, 8'h99, 8'hF0, 8'hFE, 8'hFF};

   initial begin
      // Idle inputs: zero plus zero.
      @(negedge clk);
      check("R1", 0);

      // Named boundary cases.
      apply(0, 8'hFF, 8'h01, 8'h00, "R1");
      apply(1, 8'h99, 8'h01, 8'h00, "R2");
      apply(1, 8'h45, 8'h55, 8'h00, "R2");
      apply(2, 8'h00, 8'h01, 8'hFF, "R3");
      apply(3, 8'h00, 8'h01, 8'h99, "R4");
      apply(3, 8'h10, 8'h01, 8'h09, "R4");
      apply(4, 8'hF0, 8'h3C, 8'h30, "R5");
      apply(5, 8'hF0, 8'h0C, 8'hFC, "R6");
      apply(6, 8'hAA, 8'hFF, 8'h55, "R7");
      apply(7, 8'h5A, 8'h5A, 8'h00, "R8");
      apply(7, 8'h5A, 8'h5B, 8'hFF, "R8");
      apply(1, 8'h0F, 8'h00, 8'h15, "R9");
      apply(3, 8'h00, 8'h0F, 8'h9B, "R9");

      // R10: inputs changed between edges show at once, no clock needed.
      @(negedge clk);
      #1 fn_sel = 3'd0; op_a = 8'h12; op_b = 8'h34;
      #1 check("R10", 8'h46);
      fn_sel = 3'd7;
      #1 check("R10", 8'hFF);

      // Corner pairs and random operands for every code.
      for (int s = 0; s < 8; s++) begin
         for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
               apply(s, corner[i], corner[j], model(s, corner[i], corner[j]),
                     tag(s, corner[i], corner[j]));
         for (int k = 0; k < 8000; k++) begin
            int a = int'($urandom_range(0, 255));
            int b = int'($urandom_range(0, 255));
            apply(s, a, b, model(s, a, b), tag(s, a, b));
         end
      end

      // Every valid decimal pair against decimal arithmetic.
      for (int x = 0; x < 100; x++)
         for (int y = 0; y < 100; y++) begin
            int pa = (x / 10) * 16 + x % 10;
            int pb = (y / 10) * 16 + y % 10;
            int sm = (x + y) % 100;
            int df = (x - y + 100) % 100;
            apply(1, pa, pb, (sm / 10) * 16 + sm % 10, "R2");
            apply(3, pa, pb, (df / 10) * 16 + df % 10, "R4");
         end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule